// File: doc/BRIEF.md
# Table-Driven Programmable Clock Divider

This block divides a source clock by a ratio picked from a small fixed lookup table. A 3-bit select code chooses one of eight entries, and a build-time parameter chooses which of four tables is used. Some tables are non-linear: two codes can share one ratio, and one table contains odd ratios. For odd ratios the output is built from both edges of the source clock so that the duty cycle stays at one half.

Software or a neighbouring block drives the select code at any time. The divider samples a new code only when the current output period has finished, so a ratio change never shortens a high or a low phase. An enable input stops the output cleanly. A status output reports the ratio that the running period uses.

Top module: `clk_ratio_div`

## Requirements
- R1: With TABLE_SEL = 0, select code n (0 to 7) gives an output period of 4*(n+1) source cycles.
- R2: With TABLE_SEL = 1, select code n gives an output period of 2*(n+1) source cycles.
- R3: With TABLE_SEL = 2, codes 0 and 1 give a period of 2 source cycles, and code n for n from 2 to 7 gives n+1 source cycles (3, 4, 5, 6, 7, 8).
- R4: With TABLE_SEL = 3, codes 0 and 1 give a period of 4 source cycles, and code n for n from 2 to 7 gives 2*(n+1) source cycles (6 up to 16).
- R5: For every ratio N the output is high for exactly N/2 source cycles per period; for odd N this is a whole number of cycles plus one half, using the source falling edge.
- R6: A change of the select code while enabled takes effect only at the end of the output period in progress; that period completes with its old high and low lengths.
- R7: ratioNow gives the ratio in effect as an unsigned integer; while enabled it changes on the same source rising edge on which the output period with the new ratio begins.
- R8: While enable is low the output stays low and the period counter is held at zero, and ratioNow follows the select code one source edge later; after re-enabling, the first period has its full length.
- R9: While rstN is low the output is low and ratioNow equals the table's ratio for code 0.
- R10: On the first source rising edge at which enable is sampled high, a period begins: for an even ratio the output rises at that edge, for an odd ratio at the source falling edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the divider when high; holds the output low when low |
| selCode | input | 3 | Select code looked up in the chosen ratio table |
| divClk | output | 1 | Divided clock |
| ratioNow | output | 6 | Ratio used by the current output period |

## Verification
The bench measures period and high time of every code in all four tables side by side, so a table entry off by one or a half-cycle duty error on the odd engine ratios shows up as a wrong nanosecond count. It switches from the slowest to the fastest ratio in the middle of a high phase; a design that loaded the code at once would cut that phase short and move ratioNow early. It drops enable mid-period and re-enables it, which catches a counter that resumes where it stopped (a short first period) and an odd output that rises on the wrong edge.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  localparam int SEL_W   = 3;
  localparam int RATIO_W = 6;

  // Table kinds: 0 general, 1 legacy, 2 engine, 3 network.
  localparam int KIND_GENERAL = 0;
  localparam int KIND_LEGACY  = 1;
  localparam int KIND_ENGINE  = 2;
  localparam int KIND_NETWORK = 3;

  typedef struct packed {
    logic hold;     // enable low: force output low
    logic setHigh;  // a new period starts at this edge
    logic clrHigh;  // the high phase ends at this edge
  } divStrobe_t;

  function automatic logic [RATIO_W-1:0] ratioOf(int kind, logic [SEL_W-1:0] code);
    logic [RATIO_W-1:0] step;
    logic               lowPair;
    step    = RATIO_W'(code) + RATIO_W'(1);
    lowPair = (code < SEL_W'(2));
    case (kind)
      KIND_LEGACY:  return RATIO_W'(step << 1);
      KIND_ENGINE:  return lowPair ? RATIO_W'(2) : step;
      KIND_NETWORK: return lowPair ? RATIO_W'(4) : RATIO_W'(step << 1);
      default:      return RATIO_W'(step << 2);
    endcase
  endfunction

endpackage

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int TABLE_SEL = KIND_GENERAL
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [SEL_W-1:0]   selCode,
  output divStrobe_t         strobe,
  output logic [RATIO_W-1:0] ratioNow
);

  localparam logic [RATIO_W-1:0] RESET_RATIO = ratioOf(TABLE_SEL, SEL_W'(0));

  logic [RATIO_W-1:0] nextRatio;
  logic [RATIO_W-1:0] curRatio;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] highLen;
  logic               running;
  logic               wrap;

  assign nextRatio = ratioOf(TABLE_SEL, selCode);

  // Rounded-up half: N/2 for even N, (N+1)/2 for odd N.
  assign highLen = (curRatio + RATIO_W'(1)) >> 1;
  assign wrap    = running && (cnt == curRatio - RATIO_W'(1));

  always_comb begin
    strobe.hold    = !enable;
    strobe.setHigh = enable && (!running || wrap);
    strobe.clrHigh = enable && running && !wrap && (cnt + RATIO_W'(1) == highLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      running  <= 1'b0;
      curRatio <= RESET_RATIO;
    end else if (!enable) begin
      cnt      <= '0;
      running  <= 1'b0;
      curRatio <= nextRatio;
    end else if (!running || wrap) begin
      cnt      <= '0;
      running  <= 1'b1;
      curRatio <= nextRatio;
    end else begin
      cnt <= cnt + RATIO_W'(1);
    end
  end

  assign ratioNow = curRatio;

  // Counter never leaves the current period.
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt < curRatio));

  // Inside a running period the ratio in use does not move.
  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (running && !wrap && enable) |=> $stable(curRatio));

endmodule

// File: rtl/clk_ratio_wave.sv
module clk_ratio_wave
  import clk_ratio_pkg::*;
#(
  parameter int TABLE_SEL = KIND_GENERAL
) (
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  input  logic       oddNow,
  output logic       divClk
);

  localparam bit HAS_ODD = (TABLE_SEL == KIND_ENGINE);

  logic hiPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               hiPos <= 1'b0;
    else if (strobe.hold)    hiPos <= 1'b0;
    else if (strobe.setHigh) hiPos <= 1'b1;
    else if (strobe.clrHigh) hiPos <= 1'b0;
  end

  generate
    if (HAS_ODD) begin : g_odd
      logic hiNeg;
      // Half-cycle delayed copy trims the odd high phase by half a cycle.
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) hiNeg <= 1'b0;
        else       hiNeg <= hiPos;
      end
      assign divClk = oddNow ? (hiPos & hiNeg) : hiPos;
    end else begin : g_even
      logic unusedOdd;
      assign unusedOdd = oddNow;
      assign divClk    = hiPos;
    end
  endgenerate

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> !hiPos);

  // A new period may only start from a completed low phase.
  assert_fresh_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setHigh |-> !hiPos);

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.hold, strobe.setHigh, strobe.clrHigh}));

endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
  import clk_ratio_pkg::*;
#(
  parameter int TABLE_SEL = KIND_GENERAL
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [SEL_W-1:0]   selCode,
  output logic               divClk,
  output logic [RATIO_W-1:0] ratioNow
);

  divStrobe_t strobe;

  clk_ratio_ctrl #(.TABLE_SEL(TABLE_SEL)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .selCode  (selCode),
    .strobe   (strobe),
    .ratioNow (ratioNow)
  );

  clk_ratio_wave #(.TABLE_SEL(TABLE_SEL)) i_wave (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .oddNow (ratioNow[0]),
    .divClk (divClk)
  );

endmodule

// File: tb/test_clk_ratio_div.sv
`timescale 1ns/1ps
module test_clk_ratio_div;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] selCode = 3'd0;

  logic       outs   [4];
  logic [5:0] ratios [4];
  int         measPer[4];
  int         measHi [4];

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_tab
    logic    divClkG;
    logic [5:0] ratioG;
    realtime lastRise = 0.0;
    int      perNs = 0;
    int      hiNs  = 0;

    clk_ratio_div #(.TABLE_SEL(g)) i_clk_ratio_div (
      .clk      (clk),
      .rstN     (rstN),
      .enable   (enable),
      .selCode  (selCode),
      .divClk   (divClkG),
      .ratioNow (ratioG)
    );

    always @(posedge divClkG) begin
      if (lastRise > 0.0) perNs = int'($realtime - lastRise);
      lastRise = $realtime;
    end
    always @(negedge divClkG) hiNs = int'($realtime - lastRise);

    assign outs[g]    = divClkG;
    assign ratios[g]  = ratioG;
    assign measPer[g] = perNs;
    assign measHi[g]  = hiNs;
  end

  // Expected ratios written from the requirement text.
  function automatic int expRatio(int kind, int code);
    case (kind)
      0: return 4 * (code + 1);                        // R1
      1: return 2 * (code + 1);                        // R2
      2: return (code <= 1) ? 2 : code + 1;            // R3
      default: return (code <= 1) ? 4 : 2 * code + 2;  // R4
    endcase
  endfunction

  function automatic string tabReq(int kind);
    case (kind)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  task automatic test_reset();
    #22;
    for (int t = 0; t < 4; t++) begin
      check(outs[t] == 1'b0, "R9", "output in reset", int'(outs[t]), 0);
      check(int'(ratios[t]) == expRatio(t, 0), "R9", "ratioNow in reset",
            int'(ratios[t]), expRatio(t, 0));
    end
    @(posedge clk); #2 rstN = 1'b1;
  endtask

  task automatic test_sweep();
    @(posedge clk); #2 enable = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #2 selCode = 3'(c);
      repeat (130) @(posedge clk);
      #2;
      for (int t = 0; t < 4; t++) begin
        check(measPer[t] == expRatio(t, c) * 10, tabReq(t), "period ns",
              measPer[t], expRatio(t, c) * 10);
        check(measHi[t] == expRatio(t, c) * 5, "R5", "high time ns",
              measHi[t], expRatio(t, c) * 5);
        check(int'(ratios[t]) == expRatio(t, c), "R7", "ratioNow steady",
              int'(ratios[t]), expRatio(t, c));
      end
    end
  endtask

  // General table: 32 -> 4 requested during a high phase.
  task automatic test_change_midperiod();
    @(posedge clk); #2 selCode = 3'd7;
    repeat (130) @(posedge clk);
    wait (outs[0] == 1'b0);
    wait (outs[0] == 1'b1);
    #42 selCode = 3'd0;
    #110;
    check(outs[0] == 1'b1, "R6", "old high phase intact", int'(outs[0]), 1);
    check(ratios[0] == 6'd32, "R6", "old ratio kept", int'(ratios[0]), 32);
    #10;
    check(outs[0] == 1'b0, "R6", "old high phase ends at 16", int'(outs[0]), 0);
    #150;
    check(outs[0] == 1'b0, "R6", "old low phase intact", int'(outs[0]), 0);
    check(ratios[0] == 6'd32, "R7", "ratio before boundary", int'(ratios[0]), 32);
    #10;
    check(outs[0] == 1'b1, "R6", "new period starts", int'(outs[0]), 1);
    check(ratios[0] == 6'd4, "R7", "ratio at boundary", int'(ratios[0]), 4);
    #20;
    check(outs[0] == 1'b0, "R1", "new high length", int'(outs[0]), 0);
    #20;
    check(outs[0] == 1'b1, "R1", "new period length", int'(outs[0]), 1);
  endtask

  task automatic test_disable();
    @(posedge clk); #2 selCode = 3'd3;
    repeat (130) @(posedge clk);
    wait (outs[1] == 1'b0);
    wait (outs[1] == 1'b1);
    #32 enable = 1'b0;
    #10;
    for (int t = 0; t < 4; t++)
      check(outs[t] == 1'b0, "R8", "output low when disabled", int'(outs[t]), 0);
    selCode = 3'd5;
    #20;
    check(ratios[1] == 6'd12, "R8", "ratio follows select while idle",
          int'(ratios[1]), 12);
    check(ratios[2] == 6'd6, "R8", "ratio follows select while idle",
          int'(ratios[2]), 6);
    repeat (15) @(posedge clk);
    #2;
    for (int t = 0; t < 4; t++)
      check(outs[t] == 1'b0, "R8", "output stays low", int'(outs[t]), 0);
    selCode = 3'd2;
    @(posedge clk); #2 enable = 1'b1;
    #7;
    check(outs[1] == 1'b0, "R10", "low before enable edge", int'(outs[1]), 0);
    #2;
    check(outs[1] == 1'b1, "R10", "even rises at enable edge", int'(outs[1]), 1);
    check(outs[2] == 1'b0, "R10", "odd waits half cycle", int'(outs[2]), 0);
    check(ratios[2] == 6'd3, "R7", "ratio at enable edge", int'(ratios[2]), 3);
    #5;
    check(outs[2] == 1'b1, "R10", "odd rises at falling edge", int'(outs[2]), 1);
    #13;
    check(outs[2] == 1'b1, "R5", "odd high 1.5 cycles", int'(outs[2]), 1);
    #2;
    check(outs[2] == 1'b0, "R5", "odd high ends", int'(outs[2]), 0);
    #8;
    check(outs[1] == 1'b1, "R8", "first period full high", int'(outs[1]), 1);
    #2;
    check(outs[1] == 1'b0, "R8", "first period high ends", int'(outs[1]), 0);
    #28;
    check(outs[1] == 1'b0, "R8", "first period full low", int'(outs[1]), 0);
    #2;
    check(outs[1] == 1'b1, "R8", "second period starts", int'(outs[1]), 1);
  endtask

  initial begin
    #1_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    test_reset();
    test_sweep();
    test_change_midperiod();
    test_disable();
    repeat (5) @(posedge clk);
    finishRun();
  end

endmodule